// File: doc/BRIEF.md
# Segment Descriptor Entry Fetcher

The block takes a 16-bit segment selector and finds the 8-byte descriptor that it names. Bit 2 of the selector picks the table: the global table, whose base and limit come from a register input, or the local table, whose base, raw limit, granularity bit and valid flag come from a cached-descriptor input. The block scales the limit, forms the entry address as base plus eight times the index (selector bits 15:3), and checks that the whole 8-byte entry lies inside the limit. Only after that check passes does it issue one read or one write of the 64-bit entry on a request/acknowledge memory port.

A caller pulses `start` with a selector, a direction and (for a write-back) the entry data. It then waits for the one-cycle `done` pulse. The result comes back as a status code: success, a general-protection fault with an error code derived from the selector, or a memory fault that the port reported, along with the address that faulted. The results stay unchanged until the next accepted start.

Top module: `desc_entry_fetch`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `mem_req` and `mem_we` are 0 and `status` is 0.
- R2: Selector bit 2 selects the table: 0 uses `gdt_base`/`gdt_limit`, 1 uses `ldt_base` and the scaled local limit.
- R3: When bit 2 is 1 and `ldt_valid` is 0, the local base and limit are both treated as zero, so any such selector takes a general-protection fault.
- R4: When `ldt_gran` is 1, the local limit is `{ldt_raw_limit, 12'hFFF}`; otherwise it is `ldt_raw_limit` zero-extended.
- R5: The address presented on `mem_addr` is table base + (selector >> 3) × 8, modulo 2^ADDR_W.
- R6: If the effective limit is less than index × 8 + 7, the block reports status 1 (general protection) and never raises `mem_req` for that operation. Equality passes.
- R7: On a general-protection fault, `err_code` equals the selector with bits 1:0 cleared. On any other outcome it is 0.
- R8: A read (`write_en`=0) that completes without fault returns status 0 and the 64-bit `mem_rdata` on `rdata`. A write (`write_en`=1) drives `mem_we`=1 and `mem_wdata`=`wdata`, and returns `rdata`=0.
- R9: When `mem_fault` accompanies `mem_ack`, the block reports status 2 and puts the entry address on `fault_addr`. Otherwise `fault_addr` is 0.
- R10: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start until `done`, and never together with `done`. A `start` while busy is ignored. The result outputs hold stable until the next accepted start.
- R11: `mem_req` stays high, with `mem_addr` stable, until the cycle in which `mem_ack` is sampled. It then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an access (accepted when idle) |
| selector | input | 16 | Segment selector |
| write_en | input | 1 | 1 = write entry back, 0 = read entry |
| wdata | input | 64 | Entry data for a write |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table limit (bytes − 1) |
| ldt_base | input | 32 | Cached local table base |
| ldt_raw_limit | input | 20 | Cached local table raw limit |
| ldt_gran | input | 1 | Local limit granularity (1 = 4 KiB units) |
| ldt_valid | input | 1 | Cached local descriptor is valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Memory response strobe |
| mem_fault | input | 1 | Memory response carries a fault |
| mem_rdata | input | 64 | Read data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 general protection, 2 memory fault |
| err_code | output | 16 | Fault error code |
| fault_addr | output | 32 | Address of a memory fault |
| rdata | output | 64 | Entry read |

## Verification
The hardest conditions to reach are the two edges of the limit comparison. One is an entry whose last byte sits exactly on the limit. The other is the scaled local limit, where a raw limit of 1 with granularity set must admit index 0x3FF and reject 0x400. The stimulus reaches them by building each table from its inputs, so that the chosen selectors land on those edges. A second awkward case is a memory fault together with a start that arrives while the request is pending. The bench memory model raises a fault for any address with bit 31 set and acknowledges after a fixed delay, which leaves a window in which a second start is pulsed and must leave no trace.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_GP   = 2'd1,
    ST_MEMF = 2'd2
  } fetch_status_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_CHECK = 2'd1,
    FS_WAIT  = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/dtf_table_sel.sv
module dtf_table_sel #(
  parameter int ADDR_W = 32,
  parameter int GLIM_W = 16,
  parameter int LLIM_W = 20,
  parameter int GRAN_SH = 12,
  localparam int EL_W = LLIM_W + GRAN_SH
) (
  input  logic              use_local,
  input  logic [ADDR_W-1:0] gbl_base,
  input  logic [GLIM_W-1:0] gbl_limit,
  input  logic [ADDR_W-1:0] loc_base,
  input  logic [LLIM_W-1:0] loc_raw,
  input  logic              loc_gran,
  input  logic              loc_valid,
  output logic [ADDR_W-1:0] tbl_base,
  output logic [EL_W-1:0]   tbl_limit
);
  logic [EL_W-1:0] loc_scaled;

  always_comb begin
    if (loc_gran) loc_scaled = {loc_raw, {GRAN_SH{1'b1}}};
    else          loc_scaled = {{GRAN_SH{1'b0}}, loc_raw};
  end

  always_comb begin
    if (use_local) begin
      tbl_base  = loc_valid ? loc_base : '0;
      tbl_limit = loc_valid ? loc_scaled : '0;
    end else begin
      tbl_base  = gbl_base;
      tbl_limit = {{(EL_W-GLIM_W){1'b0}}, gbl_limit};
    end
  end
endmodule

// File: rtl/dtf_bound_chk.sv
module dtf_bound_chk #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int EL_W   = 32,
  localparam int IDX_W = SEL_W - 3
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] base,
  input  logic [EL_W-1:0]   limit,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              over_limit,
  output logic [SEL_W-1:0]  gp_code
);
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] last_byte;
  logic [SEL_W-1:0] first_byte;

  assign idx        = sel[SEL_W-1:3];
  assign first_byte = {idx, 3'b000};
  assign last_byte  = {idx, 3'b111};
  assign entry_addr = base + ADDR_W'(first_byte);
  assign over_limit = limit < EL_W'(last_byte);
  assign gp_code    = {sel[SEL_W-1:2], 2'b00};
endmodule

// File: rtl/dtf_ctrl.sv
module dtf_ctrl
  import dtf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int DATA_W = 64,
  parameter int EL_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic              we_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [EL_W-1:0]   limit_in,
  output logic [SEL_W-1:0]  sel_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [EL_W-1:0]   limit_q,
  input  logic [ADDR_W-1:0] entry_addr,
  input  logic              over_limit,
  input  logic [SEL_W-1:0]  gp_code,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_fault,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [SEL_W-1:0]  err_code,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [DATA_W-1:0] rdata
);
  fetch_state_e      state;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= FS_IDLE;
      sel_q      <= '0;
      base_q     <= '0;
      limit_q    <= '0;
      we_q       <= 1'b0;
      wdata_q    <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      status     <= ST_OK;
      err_code   <= '0;
      fault_addr <= '0;
      rdata      <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        FS_IDLE: begin
          if (start) begin
            sel_q   <= sel_in;
            base_q  <= base_in;
            limit_q <= limit_in;
            we_q    <= we_in;
            wdata_q <= wdata_in;
            busy    <= 1'b1;
            state   <= FS_CHECK;
          end
        end
        FS_CHECK: begin
          if (over_limit) begin
            status     <= ST_GP;
            err_code   <= gp_code;
            fault_addr <= '0;
            rdata      <= '0;
            busy       <= 1'b0;
            done       <= 1'b1;
            state      <= FS_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= we_q;
            mem_addr  <= entry_addr;
            mem_wdata <= wdata_q;
            state     <= FS_WAIT;
          end
        end
        FS_WAIT: begin
          if (mem_ack) begin
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b1;
            err_code <= '0;
            state    <= FS_IDLE;
            if (mem_fault) begin
              status     <= ST_MEMF;
              fault_addr <= mem_addr;
              rdata      <= '0;
            end else begin
              status     <= ST_OK;
              fault_addr <= '0;
              rdata      <= we_q ? '0 : mem_rdata;
            end
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  // R11: request held with a stable address until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R6: a limit violation finishes without touching memory
  p_gp_no_mem_r6: assert property (@(posedge clk) disable iff (rst)
    (state == FS_CHECK && over_limit) |=> (!mem_req && done && status == ST_GP));

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: busy and done never overlap
  p_busy_done_r10: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R10: results stay put while idle without a start
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (state == FS_IDLE && !start) |=> ($stable(status) && $stable(rdata) && $stable(err_code)));

  // R7: error code never carries the low selector bits
  p_err_low_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (err_code[1:0] == 2'b00));
endmodule

// File: rtl/desc_entry_fetch.sv
module desc_entry_fetch #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int DATA_W = 64,
  parameter int GLIM_W = 16,
  parameter int LLIM_W = 20,
  localparam int GRAN_SH = 12,
  localparam int EL_W = LLIM_W + GRAN_SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  selector,
  input  logic              write_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [GLIM_W-1:0] gdt_limit,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [LLIM_W-1:0] ldt_raw_limit,
  input  logic              ldt_gran,
  input  logic              ldt_valid,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_fault,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [SEL_W-1:0]  err_code,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [DATA_W-1:0] rdata
);
  logic [ADDR_W-1:0] sel_base;
  logic [EL_W-1:0]   sel_limit;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] base_q;
  logic [EL_W-1:0]   limit_q;
  logic [ADDR_W-1:0] entry_addr;
  logic              over_limit;
  logic [SEL_W-1:0]  gp_code;

  dtf_table_sel #(
    .ADDR_W(ADDR_W), .GLIM_W(GLIM_W), .LLIM_W(LLIM_W), .GRAN_SH(GRAN_SH)
  ) u_tsel (
    .use_local (selector[2]),
    .gbl_base  (gdt_base),
    .gbl_limit (gdt_limit),
    .loc_base  (ldt_base),
    .loc_raw   (ldt_raw_limit),
    .loc_gran  (ldt_gran),
    .loc_valid (ldt_valid),
    .tbl_base  (sel_base),
    .tbl_limit (sel_limit)
  );

  dtf_bound_chk #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .EL_W(EL_W)
  ) u_bchk (
    .sel        (sel_q),
    .base       (base_q),
    .limit      (limit_q),
    .entry_addr (entry_addr),
    .over_limit (over_limit),
    .gp_code    (gp_code)
  );

  dtf_ctrl #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .DATA_W(DATA_W), .EL_W(EL_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sel_in     (selector),
    .we_in      (write_en),
    .wdata_in   (wdata),
    .base_in    (sel_base),
    .limit_in   (sel_limit),
    .sel_q      (sel_q),
    .base_q     (base_q),
    .limit_q    (limit_q),
    .entry_addr (entry_addr),
    .over_limit (over_limit),
    .gp_code    (gp_code),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_fault  (mem_fault),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .err_code   (err_code),
    .fault_addr (fault_addr),
    .rdata      (rdata)
  );
endmodule

// File: tb/desc_entry_fetch_test.sv
`timescale 1ns/1ps
module desc_entry_fetch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] selector = '0;
  logic        write_en = 1'b0;
  logic [63:0] wdata = '0;
  logic [31:0] gdt_base = 32'h0000_1000;
  logic [15:0] gdt_limit = 16'h00FF;
  logic [31:0] ldt_base = 32'h0000_2000;
  logic [19:0] ldt_raw_limit = 20'h0003F;
  logic        ldt_gran = 1'b0;
  logic        ldt_valid = 1'b1;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic        mem_fault = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        busy, done;
  logic [1:0]  status;
  logic [15:0] err_code;
  logic [31:0] fault_addr;
  logic [63:0] rdata;

  int checks = 0;
  int fails = 0;
  int req_cycles = 0;
  int done_cnt = 0;
  int lat = 0;
  logic [31:0] last_req_addr = '0;
  logic [31:0] w_addr = 32'hFFFF_FFFF;
  logic [63:0] w_data = '0;
  logic        saw_we = 1'b0;

  always #2.5 clk = ~clk;

  desc_entry_fetch uut (
    .clk(clk), .rst(rst), .start(start), .selector(selector),
    .write_en(write_en), .wdata(wdata), .gdt_base(gdt_base),
    .gdt_limit(gdt_limit), .ldt_base(ldt_base), .ldt_raw_limit(ldt_raw_limit),
    .ldt_gran(ldt_gran), .ldt_valid(ldt_valid), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_fault(mem_fault), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .status(status), .err_code(err_code),
    .fault_addr(fault_addr), .rdata(rdata)
  );

  function automatic logic [63:0] pattern(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  // memory model: acknowledges on the second sampled cycle of a request
  initial begin
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
      if (mem_req && !mem_ack) begin
        req_cycles++;
        last_req_addr = mem_addr;
        if (lat == 1) begin
          mem_ack = 1'b1;
          mem_fault = mem_addr[31];
          if (mem_we) begin
            saw_we = 1'b1;
            w_addr = mem_addr;
            w_data = mem_wdata;
            mem_rdata = '0;
          end else begin
            mem_rdata = (mem_addr == w_addr) ? w_data : pattern(mem_addr);
          end
          lat = 0;
        end else begin
          lat++;
        end
      end else begin
        mem_ack = 1'b0;
        mem_fault = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] s, input logic we, input logic [63:0] wd);
    int guard;
    @(negedge clk);
    selector = s; write_en = we; wdata = wd; start = 1'b1;
    req_cycles = 0; done_cnt = 0; saw_we = 1'b0;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  typedef struct packed {
    logic [15:0] sel;
    logic        lv;
    logic [1:0]  st;
    logic [31:0] val;
  } vec_t;

  // GDT: base 0x1000 limit 0xFF; LDT: base 0x2000 limit 0x3F, no granularity
  localparam vec_t VECS [7] = '{
    '{16'h0008, 1'b1, 2'd0, 32'h0000_1008},
    '{16'h00FB, 1'b1, 2'd0, 32'h0000_10F8},
    '{16'h0103, 1'b1, 2'd1, 32'h0000_0100},
    '{16'h000C, 1'b1, 2'd0, 32'h0000_2008},
    '{16'h003E, 1'b1, 2'd0, 32'h0000_2038},
    '{16'h0045, 1'b1, 2'd1, 32'h0000_0044},
    '{16'h0004, 1'b0, 2'd1, 32'h0000_0004}
  };

  initial begin
    #50000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req && !mem_we && status == 2'd0, "R1 reset",
        {59'd0, busy, done, mem_req, mem_we, status == 2'd0}, 64'd1);
    rst = 1'b0;

    for (int i = 0; i < 7; i++) begin
      ldt_valid = VECS[i].lv;
      run_op(VECS[i].sel, 1'b0, '0);
      chk(status == VECS[i].st, "R2/R6 status", {62'd0, status}, {62'd0, VECS[i].st});
      if (VECS[i].st == 2'd0) begin
        chk(last_req_addr == VECS[i].val, "R2/R5 address", {32'd0, last_req_addr}, {32'd0, VECS[i].val});
        chk(rdata == pattern(VECS[i].val), "R8 read data", rdata, pattern(VECS[i].val));
        chk(err_code == 16'd0 && fault_addr == 32'd0, "R7/R9 clean outputs", {32'd0, fault_addr}, 64'd0);
      end else begin
        chk(err_code == VECS[i].val[15:0], "R7 error code", {48'd0, err_code}, {32'd0, VECS[i].val});
        chk(req_cycles == 0, "R6 no memory access", req_cycles, 64'd0);
        if (!VECS[i].lv) chk(1'b1 && status == 2'd1, "R3 invalid local table", {62'd0, status}, 64'd1);
      end
    end
    ldt_valid = 1'b1;

    // R4 granularity: raw 1, gran 1 -> limit 0x1FFF
    ldt_raw_limit = 20'h00001; ldt_gran = 1'b1;
    run_op(16'h1FFC, 1'b0, '0);
    chk(status == 2'd0 && last_req_addr == 32'h0000_3FF8, "R4 scaled limit pass",
        {30'd0, status, last_req_addr}, {32'd0, 32'h0000_3FF8});
    run_op(16'h2004, 1'b0, '0);
    chk(status == 2'd1 && err_code == 16'h2004, "R4 scaled limit reject",
        {30'd0, status, 16'd0, err_code}, {30'd1, 32'h0000_2004});
    ldt_gran = 1'b0; ldt_raw_limit = 20'h0003F;
    run_op(16'h0404, 1'b0, '0);
    chk(status == 2'd1, "R4 unscaled limit", {62'd0, status}, 64'd1);

    // R8 write then read back
    run_op(16'h0010, 1'b1, 64'hDEAD_BEEF_0123_4567);
    chk(saw_we && w_addr == 32'h0000_1010 && w_data == 64'hDEAD_BEEF_0123_4567,
        "R8 write beat", w_data, 64'hDEAD_BEEF_0123_4567);
    chk(status == 2'd0 && rdata == 64'd0, "R8 write result", rdata, 64'd0);
    run_op(16'h0010, 1'b0, '0);
    chk(rdata == 64'hDEAD_BEEF_0123_4567, "R8 read back", rdata, 64'hDEAD_BEEF_0123_4567);

    // R9 memory fault, with R10 start during busy
    gdt_base = 32'h8000_0000;
    @(negedge clk);
    selector = 16'h0010; write_en = 1'b0; start = 1'b1;
    req_cycles = 0; done_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    selector = 16'h0020; start = 1'b1;   // ignored: block is busy
    chk(busy, "R10 busy during access", {63'd0, busy}, 64'd1);
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < 20 && !done; g++) @(negedge clk);
    chk(status == 2'd2 && fault_addr == 32'h8000_0010, "R9 memory fault",
        {30'd0, status, fault_addr}, {30'd2, 32'h8000_0010});
    chk(req_cycles == 2, "R11 request held until ack", req_cycles, 64'd2);
    repeat (6) @(negedge clk);
    chk(done_cnt == 1 && status == 2'd2 && fault_addr == 32'h8000_0010 && !busy,
        "R10 start while busy ignored, result held", done_cnt, 64'd1);
    gdt_base = 32'h0000_1000;

    // R1 reset again mid-stream clears outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(status == 2'd0 && !busy && !mem_req, "R1 reset after activity", {62'd0, status}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule